// File: doc/BRIEF.md
# Link Pin-Level Frame Serializer

This block helps find bridged and open traces on a 12-line parallel link between an FPGA and a microcontroller. Ten of the link lines are used as test inputs: the eight shared address/data lines plus two of the four strobe lines. The other two lines stay free for the test host's own signalling. The block takes a snapshot of the ten levels and sends it out on a single serial pin. It repeats this without end, so a host can drive any pattern it likes onto the lines and read back what the FPGA actually saw.

Each 31-bit frame carries its own framing. It opens with twenty zeros, then a single one that marks where the data starts, then the ten captured levels in line order. Frames follow each other with no gap. A receiver with no shared framing can therefore lock on by watching for a one that comes after at least twenty zeros. The same bit stream can also drive the board LED, which is the only indicator that can be trusted on a suspect board.

Top module: `pinframe_serializer`

## Requirements
- R1: Frames are 31 bit periods long and follow each other with no gap. Bit positions 0 to 30 repeat endlessly, and each position lasts exactly one clock.
- R2: Bit positions 0 through 19 of every frame drive `ser_out` low.
- R3: Bit position 20 of every frame drives `ser_out` high. This is the start-of-data marker.
- R4: Bit position 21+i (i = 0..9) drives `ser_out` with the captured level of `pins_in[i]`, so line 0 goes first and line 9 goes last.
- R5: All ten levels are captured together once per frame, at the clock edge that ends position 0. An input change after that edge does not alter the current frame and shows up in the next frame.
- R6: Every input passes through a two-stage synchroniser. A change applied in the cycle of position 29 or earlier is seen in the next frame. A change applied in the cycle of position 30 misses the next frame and appears in the frame after it.
- R7: While `rst` is high, `ser_out` is low. After `rst` falls, the first bit period is position 0 of a new frame.
- R8: `led_out` equals `ser_out` in every cycle.
- R9: A high bit that follows twenty or more consecutive low bits is always the position-20 marker. Data can never pose as a preamble followed by a marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one serial bit per period |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | 10 | Asynchronous levels of the ten link lines under test |
| ser_out | output | 1 | Framed serial bit stream |
| led_out | output | 1 | LED drive, a copy of the serial stream |

## Verification
The assertions assume that `rst` changes only away from the rising clock edge and that `pins_in` may change at any time. Only the R5 and R6 capture checks rely on the inputs staying steady across the synchroniser window before a capture edge. The bench changes the inputs on falling edges, at chosen bit positions. Position 25 is used for the exhaustive sweep, and positions 29 and 30 probe the synchroniser boundary. Every expected frame is therefore known exactly from the R6 latency rule. The sweep covers all 1024 input patterns. The all-zero pattern produces thirty consecutive zeros across a frame boundary, which exercises the R9 lock-on condition.

// File: rtl/pinframe_pkg.sv
package pinframe_pkg;

    localparam int DEF_PINS       = 10;
    localparam int DEF_ZERO_RUN   = 20;
    localparam int DEF_SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SEG_ZERO = 2'd0,
        SEG_MARK = 2'd1,
        SEG_DATA = 2'd2
    } seg_e;

    typedef struct packed {
        seg_e seg;
        logic first;
        logic last;
    } frame_tag_t;

    function automatic int frame_length(input int zero_run, input int pins);
        return zero_run + 1 + pins;
    endfunction

    function automatic seg_e seg_for(input int pos, input int zero_run);
        if (pos < zero_run)
            return SEG_ZERO;
        else if (pos == zero_run)
            return SEG_MARK;
        else
            return SEG_DATA;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] chain_q;
        always_ff @(posedge clk) begin
            chain_q <= {chain_q[DEPTH-2:0], async_in[b]};
        end
        assign sync_out[b] = chain_q[DEPTH-1];
    end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import pinframe_pkg::*;
#(
    parameter int ZERO_RUN  = 20,
    parameter int DATA_BITS = 10,
    localparam int FRAME_LEN = frame_length(ZERO_RUN, DATA_BITS),
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos,
    output frame_tag_t       tag
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (pos_q == LAST_POS)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    always_comb begin
        tag.seg   = seg_for(int'(pos_q), ZERO_RUN);
        tag.first = (pos_q == '0);
        tag.last  = (pos_q == LAST_POS);
    end

    assign pos = pos_q;

    assert_pos_range_R1: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST_POS);

    assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        tag.last |=> (pos_q == '0));

    assert_frame_step_R1: assert property (@(posedge clk) disable iff (rst)
        !tag.last |=> (pos_q == $past(pos_q) + 1'b1));

endmodule

// File: rtl/pin_snapshot.sv
module pin_snapshot
    import pinframe_pkg::*;
#(
    parameter int WIDTH    = 10,
    parameter int ZERO_RUN = 20,
    parameter int POS_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_tag_t       tag,
    input  logic [POS_W-1:0] pos,
    input  logic [WIDTH-1:0] sync_pins,
    output logic             bit_out
);

    localparam int DATA_POS = ZERO_RUN + 1;

    logic [WIDTH-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (tag.first)
            snap_q <= sync_pins;
    end

    logic data_bit;
    always_comb begin
        data_bit = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (pos == POS_W'(DATA_POS + i))
                data_bit = snap_q[i];
        end
    end

    always_comb begin
        unique case (tag.seg)
            SEG_ZERO: bit_out = 1'b0;
            SEG_MARK: bit_out = 1'b1;
            SEG_DATA: bit_out = data_bit;
            default:  bit_out = 1'b0;
        endcase
    end

    assert_snap_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !tag.first |=> $stable(snap_q));

    assert_snap_load_R5: assert property (@(posedge clk) disable iff (rst)
        tag.first |=> (snap_q == $past(sync_pins)));

endmodule

// File: rtl/pinframe_serializer.sv
module pinframe_serializer
    import pinframe_pkg::*;
#(
    parameter int PINS       = DEF_PINS,
    parameter int ZERO_RUN   = DEF_ZERO_RUN,
    parameter int SYNC_DEPTH = DEF_SYNC_DEPTH,
    parameter bit LED_MIRROR = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins_in,
    output logic            ser_out,
    output logic            led_out
);

    localparam int FRAME_LEN = frame_length(ZERO_RUN, PINS);
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int RUN_CAP   = FRAME_LEN + ZERO_RUN;
    localparam int RUN_W     = $clog2(RUN_CAP + 1);

    logic [PINS-1:0]  sync_pins;
    logic [POS_W-1:0] pos;
    frame_tag_t       tag;

    pin_sync #(
        .WIDTH (PINS),
        .DEPTH (SYNC_DEPTH)
    ) u_sync (
        .clk      (clk),
        .async_in (pins_in),
        .sync_out (sync_pins)
    );

    frame_sequencer #(
        .ZERO_RUN  (ZERO_RUN),
        .DATA_BITS (PINS)
    ) u_seq (
        .clk (clk),
        .rst (rst),
        .pos (pos),
        .tag (tag)
    );

    pin_snapshot #(
        .WIDTH    (PINS),
        .ZERO_RUN (ZERO_RUN),
        .POS_W    (POS_W)
    ) u_snap (
        .clk       (clk),
        .rst       (rst),
        .tag       (tag),
        .pos       (pos),
        .sync_pins (sync_pins),
        .bit_out   (ser_out)
    );

    if (LED_MIRROR) begin : g_led_on
        assign led_out = ser_out;
    end else begin : g_led_off
        assign led_out = 1'b0;
    end

    // Checker state: count of consecutive low bits seen before this cycle.
    logic [RUN_W-1:0] zrun_q;
    always_ff @(posedge clk) begin
        if (rst)
            zrun_q <= '0;
        else if (ser_out)
            zrun_q <= '0;
        else if (zrun_q != RUN_W'(RUN_CAP))
            zrun_q <= zrun_q + 1'b1;
    end

    assert_preamble_low_R2: assert property (@(posedge clk) disable iff (rst)
        (pos < POS_W'(ZERO_RUN)) |-> !ser_out);

    assert_marker_high_R3: assert property (@(posedge clk) disable iff (rst)
        (pos == POS_W'(ZERO_RUN)) |-> ser_out);

    assert_lock_unique_R9: assert property (@(posedge clk) disable iff (rst)
        (ser_out && (zrun_q >= RUN_W'(ZERO_RUN))) |-> (pos == POS_W'(ZERO_RUN)));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((pos == '0) && !ser_out));

endmodule

// File: tb/pinframe_serializer_bench.sv
module pinframe_serializer_bench;

    localparam int PINS      = 10;
    localparam int ZERO_RUN  = 20;
    localparam int FRAME_LEN = ZERO_RUN + 1 + PINS;
    localparam int WATCHDOG  = 150000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PINS-1:0] pins_in = '0;
    logic            ser_out;
    logic            led_out;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    int zrun       = 0;
    bit done       = 1'b0;

    always #5 clk = ~clk;

    pinframe_serializer u_pinframe_serializer (
        .clk     (clk),
        .rst     (rst),
        .pins_in (pins_in),
        .ser_out (ser_out),
        .led_out (led_out)
    );

    task automatic check(input string req, input logic act, input logic exp, input int pos);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s pos=%0d actual=%0b expected=%0b", req, pos, act, exp);
        end
    endtask

    // Walk one frame from position 0, checking each bit at the falling edge.
    // After sampling position chg_pos, pins_in becomes new_val.
    // At position abort_pos (if < FRAME_LEN) reset is raised and the task returns.
    task automatic run_frame(input logic [PINS-1:0] exp, input int chg_pos,
                             input logic [PINS-1:0] new_val, input int abort_pos);
        for (int p = 0; p < FRAME_LEN; p++) begin
            logic e;
            if (p < ZERO_RUN)       e = 1'b0;
            else if (p == ZERO_RUN) e = 1'b1;
            else                    e = exp[p - ZERO_RUN - 1];
            if (p < ZERO_RUN)
                check("R2 R1", ser_out, e, p);
            else if (p == ZERO_RUN)
                check("R3", ser_out, e, p);
            else
                check("R4 R5 R6", ser_out, e, p);
            check("R8", led_out, ser_out, p);
            // R9: a high bit after >= ZERO_RUN lows must be the marker
            if (ser_out === 1'b1) begin
                if (zrun >= ZERO_RUN)
                    check("R9", 1'b1, (p == ZERO_RUN), p);
                zrun = 0;
            end else begin
                zrun++;
            end
            if (p == chg_pos) pins_in = new_val;
            if (p == abort_pos) begin
                rst = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R7", ser_out, 1'b0, 0);
        check("R8", led_out, 1'b0, 0);
        rst = 1'b0;  // now in position 0 of the first frame (R7)

        // Exhaustive sweep: frame f carries pattern f; next pattern set at position 25.
        for (int f = 0; f < 1024; f++) begin
            run_frame(PINS'(f), 25, PINS'(f + 1), FRAME_LEN);
        end

        // R6 boundary: change at position 29 is caught by the next frame.
        run_frame(10'h000, 29, 10'h2AA, FRAME_LEN);
        // Change at position 30 misses the next frame.
        run_frame(10'h2AA, 30, 10'h155, FRAME_LEN);
        run_frame(10'h2AA, 25, 10'h155, FRAME_LEN);
        run_frame(10'h155, 25, 10'h3FF, FRAME_LEN);

        // R7: reset in the middle of a data field showing ones.
        run_frame(10'h3FF, FRAME_LEN, 10'h3FF, 23);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7", ser_out, 1'b0, k);
            check("R8", led_out, 1'b0, k);
        end
        rst  = 1'b0;
        zrun = 0;
        run_frame(10'h3FF, 25, 10'h0F0, FRAME_LEN);
        run_frame(10'h0F0, FRAME_LEN, 10'h0F0, FRAME_LEN);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule